// File: doc/BRIEF.md
# Corrected DAC Code Front End

This block is the digital side of a self-correcting 16-bit current-steering DAC. A host writes a two's complement sample over a parallel bus, gated by an active-low chip select and an active-low write strobe. The captured word drives the ladder switches in offset-binary form. The conversion is done by flipping the top bit, so the bipolar zero code lands at mid-scale.

The top six bits of the switch word select one of sixty-four 12-bit linearity correction words. A correction table indexed by the segment can repair interaction errors between bits, which per-bit trimming cannot reach. The block also presents a 6-bit gain-trim word. That word does not depend on the data. Both trim words come from one small table. The table is filled through a separate address/data/strobe port, which works only while an active-low programming input is held low.

The level-sensitive bus register is modelled in the system clock domain:
- At every clock edge where both bus controls are low, the register takes the bus data. The switch word then shows that data from the next cycle.
- Once either control rises, the register holds its value.
- A write window that spans at least one clock edge is therefore never lost.

The correction and gain outputs are registered in the same cycle as the switch word, so a switch word and its trim words always appear together.

Top module: `dac_code_front`

## Requirements
- R1: After reset the switch word is 16'h8000, the correction output is 0 and the gain output is 6'b100000. Every correction entry reads 0 and the gain entry reads 6'b100000 until it is programmed.
- R2: At every clock edge where `csN` and `wrN` are both low, the register captures `dataIn`. The switch word shows that value, MSB inverted, from the following cycle. Consecutive edges with both controls low keep updating it (transparent behaviour).
- R3: At a clock edge where `csN` or `wrN` is high, the switch word does not change, whatever `dataIn` does.
- R4: Bit 15 of the switch word is the inverse of captured bit 15, and bits 14..0 pass unchanged. Input 16'h0000 gives 16'h8000, 16'h7FFF gives 16'hFFFF, 16'h8000 gives 16'h0000, and 16'hFFFF gives 16'h7FFF.
- R5: While programming is disabled, `corrOut` equals the correction entry indexed by switch-word bits 15..10. It changes in the same cycle as the switch word.
- R6: While programming is disabled, `gainOut` equals the gain entry for every data code.
- R7: A clock edge with `progN` low and `progStrobe` high writes the table:
  - If `progAddr[6]` is 0, the 12-bit `progData` goes to correction entry `progAddr[5:0]`.
  - If `progAddr[6]` is 1, `progData[5:0]` goes to the gain entry.
- R8: At every clock edge with `progN` low, `corrOut` and `gainOut` keep their values. From the cycle after `progN` returns high, they again follow R5 and R6 using the updated table.
- R9: With `progN` high, `progStrobe` has no effect on any table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Bus chip select, active low |
| wrN | input | 1 | Bus write strobe, active low |
| dataIn | input | 16 | Two's complement sample from the bus |
| progN | input | 1 | Table programming enable, active low (high in normal operation) |
| progStrobe | input | 1 | Table write strobe, active high |
| progAddr | input | 7 | Table address: bit 6 selects the gain entry, bits 5..0 select the correction entry |
| progData | input | 12 | Table write data (bits 5..0 only for the gain entry) |
| switchOut | output | 16 | Offset-binary drive for the ladder switches |
| corrOut | output | 12 | Correction DAC code |
| gainOut | output | 6 | Gain-trim DAC code |

## Verification
The hardest situation to reach from the ports is a switch word that changes while programming is enabled. In that case the trim outputs must stay frozen at their earlier values, and then jump to the new entries for the current segment once programming ends. The bench reaches it in three steps:
1. It opens a programming session and writes bus codes in the middle of the table writes.
2. It checks that the correction and gain outputs have not moved.
3. It releases the enable and checks the refreshed pair.

A near-exhaustive sweep then visits all sixty-four segments with several low-bit patterns. It compares each switch word and its correction word against a table computed arithmetically in the bench.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
  typedef struct packed {
    logic loadCode;    // capture bus data this edge
    logic tableWr;     // write one table entry this edge
    logic refreshOut;  // trim outputs follow the table this edge
  } frontStrobes_t;
endpackage

// File: rtl/dac_front_ctrl.sv
module dac_front_ctrl
  import dac_front_pkg::*;
(
  input  logic          csN,
  input  logic          wrN,
  input  logic          progN,
  input  logic          progStrobe,
  output frontStrobes_t strobes
);
  always_comb begin
    strobes.loadCode   = !csN && !wrN;
    strobes.tableWr    = !progN && progStrobe;
    strobes.refreshOut = progN;
  end
endmodule

// File: rtl/dac_front_datapath.sv
module dac_front_datapath
  import dac_front_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6,
  parameter int CORR_W = 12,
  parameter int GAIN_W = 6,
  localparam int ADDR_W  = IDX_W + 1,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  frontStrobes_t     strobes,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [CORR_W-1:0] progData,
  output logic [DATA_W-1:0] switchOut,
  output logic [CORR_W-1:0] corrOut,
  output logic [GAIN_W-1:0] gainOut
);
  localparam logic [DATA_W-1:0] MSB_MASK = DATA_W'(1) << (DATA_W - 1);
  localparam logic [GAIN_W-1:0] GAIN_MID = GAIN_W'(1) << (GAIN_W - 1);

  logic [DATA_W-1:0] codeReg;
  logic [DATA_W-1:0] nextCode;
  logic [DATA_W-1:0] nextSwitch;
  logic [IDX_W-1:0]  nextIdx;
  logic [CORR_W-1:0] corrTab [ENTRIES];
  logic [GAIN_W-1:0] gainEntry;

  always_comb begin
    nextCode   = strobes.loadCode ? dataIn : codeReg;
    nextSwitch = nextCode ^ MSB_MASK;
    nextIdx    = nextSwitch[DATA_W-1 -: IDX_W];
  end

  assign switchOut = codeReg ^ MSB_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg <= '0;
      corrOut <= '0;
      gainOut <= GAIN_MID;
    end else begin
      codeReg <= nextCode;
      if (strobes.refreshOut) begin
        corrOut <= corrTab[nextIdx];
        gainOut <= gainEntry;
      end
    end
  end

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          corrTab[e] <= '0;
        else if (strobes.tableWr && !progAddr[IDX_W] && progAddr[IDX_W-1:0] == IDX_W'(e))
          corrTab[e] <= progData;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      gainEntry <= GAIN_MID;
    else if (strobes.tableWr && progAddr[IDX_W])
      gainEntry <= progData[GAIN_W-1:0];
  end
endmodule

// File: rtl/dac_code_front.sv
module dac_code_front
  import dac_front_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6,
  parameter int CORR_W = 12,
  parameter int GAIN_W = 6,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              progN,
  input  logic              progStrobe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [CORR_W-1:0] progData,
  output logic [DATA_W-1:0] switchOut,
  output logic [CORR_W-1:0] corrOut,
  output logic [GAIN_W-1:0] gainOut
);
  frontStrobes_t strobes;

  dac_front_ctrl u_ctrl (
    .csN       (csN),
    .wrN       (wrN),
    .progN     (progN),
    .progStrobe(progStrobe),
    .strobes   (strobes)
  );

  dac_front_datapath #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W),
    .CORR_W(CORR_W),
    .GAIN_W(GAIN_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .dataIn   (dataIn),
    .progAddr (progAddr),
    .progData (progData),
    .switchOut(switchOut),
    .corrOut  (corrOut),
    .gainOut  (gainOut)
  );
endmodule

// File: rtl/dac_code_front_chk.sv
module dac_code_front_chk #(
  parameter int DATA_W = 16,
  parameter int CORR_W = 12,
  parameter int GAIN_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              wrN,
  input logic              progN,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] switchOut,
  input logic [CORR_W-1:0] corrOut,
  input logic [GAIN_W-1:0] gainOut
);
  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (switchOut == (DATA_W'(1) << (DATA_W - 1)) && corrOut == '0
               && gainOut == (GAIN_W'(1) << (GAIN_W - 1)))); // R1

  AST_TRANSPARENT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !wrN) |=> (switchOut[DATA_W-1] == !$past(dataIn[DATA_W-1])
                        && switchOut[DATA_W-2:0] == $past(dataIn[DATA_W-2:0]))); // R2

  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (csN || wrN) |=> $stable(switchOut)); // R3

  AST_CORR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !progN |=> $stable(corrOut)); // R8

  AST_GAIN_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !progN |=> $stable(gainOut)); // R8
endmodule

bind dac_code_front dac_code_front_chk #(
  .DATA_W(DATA_W),
  .CORR_W(CORR_W),
  .GAIN_W(GAIN_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .wrN      (wrN),
  .progN    (progN),
  .dataIn   (dataIn),
  .switchOut(switchOut),
  .corrOut  (corrOut),
  .gainOut  (gainOut)
);

// File: tb/dac_code_front_tb.sv
module dac_code_front_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        wrN = 1'b1;
  logic [15:0] dataIn = '0;
  logic        progN = 1'b1;
  logic        progStrobe = 1'b0;
  logic [6:0]  progAddr = '0;
  logic [11:0] progData = '0;
  logic [15:0] switchOut;
  logic [11:0] corrOut;
  logic [5:0]  gainOut;

  int vectors = 0;
  int fails = 0;

  always #(PERIOD / 2) clk = ~clk;

  dac_code_front u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .dataIn(dataIn),
    .progN(progN), .progStrobe(progStrobe), .progAddr(progAddr), .progData(progData),
    .switchOut(switchOut), .corrOut(corrOut), .gainOut(gainOut)
  );

  function automatic logic [11:0] corrVal(input int idx);
    return 12'((idx * 37 + 5) & 'hFFF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeCode(input logic [15:0] code);
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; dataIn = code;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1; dataIn = ~code;
  endtask

  task automatic progWrite(input logic [6:0] addr, input logic [11:0] data);
    @(negedge clk);
    progAddr = addr; progData = data; progStrobe = 1'b1;
    @(negedge clk);
    progStrobe = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] sw;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 switch", 32'(switchOut), 32'h8000);
    check("R1 corr", 32'(corrOut), 32'h0);
    check("R1 gain", 32'(gainOut), 32'h20);
    rstN = 1'b1;
    writeCode(16'h1234);
    check("R1 cleared corr entry", 32'(corrOut), 32'h0);
    check("R1 gain entry", 32'(gainOut), 32'h20);

    // R7 + R8: program the table, outputs frozen meanwhile
    @(negedge clk);
    progN = 1'b0;
    for (int i = 0; i < 64; i++) progWrite(7'(i), corrVal(i));
    progWrite(7'h40, 12'h02B);
    writeCode(16'h4321);
    check("R8 switch moves", 32'(switchOut), 32'hC321);
    check("R8 corr frozen", 32'(corrOut), 32'h0);
    check("R8 gain frozen", 32'(gainOut), 32'h20);
    @(negedge clk);
    progN = 1'b1;
    @(negedge clk);
    check("R8 corr refreshed", 32'(corrOut), 32'(corrVal(16'hC321 >> 10)));
    check("R7 gain entry", 32'(gainOut), 32'h2B);

    // R9: strobe ignored without programming enable
    progWrite(7'h40, 12'h011);
    progWrite(7'(16'hC321 >> 10), 12'h000);
    @(negedge clk);
    check("R9 gain untouched", 32'(gainOut), 32'h2B);
    check("R9 corr untouched", 32'(corrOut), 32'(corrVal(16'hC321 >> 10)));
    writeCode(16'h0000);
    writeCode(16'h4321);
    check("R9 entry kept", 32'(corrOut), 32'(corrVal(16'hC321 >> 10)));

    // R4: MSB mapping corners
    writeCode(16'h0000); check("R4 zero", 32'(switchOut), 32'h8000);
    writeCode(16'h7FFF); check("R4 max pos code", 32'(switchOut), 32'hFFFF);
    check("R5 top segment", 32'(corrOut), 32'(corrVal(63)));
    writeCode(16'h8000); check("R4 max neg code", 32'(switchOut), 32'h0000);
    check("R5 bottom segment", 32'(corrOut), 32'(corrVal(0)));
    writeCode(16'hFFFF); check("R4 minus one", 32'(switchOut), 32'h7FFF);

    // R5/R6 sweep over all segments
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 4; j++) begin
        sw = {6'(i), 10'(j * 341)};
        writeCode(sw ^ 16'h8000);
        check("R2 switch", 32'(switchOut), 32'(sw));
        check("R5 corr", 32'(corrOut), 32'(corrVal(i)));
        check("R6 gain", 32'(gainOut), 32'h2B);
      end
    end

    // R2: transparent across consecutive edges
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; dataIn = 16'h0400;
    @(negedge clk);
    check("R2 first", 32'(switchOut), 32'h8400);
    check("R5 same cycle", 32'(corrOut), 32'(corrVal(16'h8400 >> 10)));
    dataIn = 16'h2800;
    @(negedge clk);
    check("R2 second", 32'(switchOut), 32'hA800);
    wrN = 1'b1; dataIn = 16'h5555;
    // R3: either control high holds the word
    @(negedge clk);
    check("R3 wr high", 32'(switchOut), 32'hA800);
    csN = 1'b1; wrN = 1'b0; dataIn = 16'h1111;
    @(negedge clk);
    @(negedge clk);
    check("R3 cs high", 32'(switchOut), 32'hA800);
    check("R3 corr kept", 32'(corrOut), 32'(corrVal(16'hA800 >> 10)));
    wrN = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule